// File: doc/BRIEF.md
# Receiver Gain Control Loop

This block closes the digital side of an automatic gain loop in a receiver IF chain. A signal-strength estimator after the ADC delivers signed level samples in units of about 1 dB. The block compares each sample with a programmable setpoint and moves a 5-bit amplifier gain code one step (about 3 dB) at a time, so that the ADC input stays near that setpoint. The setpoint has independent margins above and below it. The code saturates at zero and at a programmable ceiling.

The same setpoint is the carrier-sense threshold. The carrier-sense comparison uses the measured level referred back to the antenna, which is the measured value plus one step size for each code below the ceiling, and it has one unit of hysteresis. Optional four-sample averaging adds a two-sample confirmation against needless gain toggling. After every gain step the loop ignores samples for a programmable settle time. It can raise a short blanking pulse so the analog path recovers from offset spikes. Once carrier sense has been steady for long enough, an optional freeze holds the gain until carrier sense drops.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the gain output equals the maximum-gain input, and the carrier-sense and blanking outputs are low.
- R2: The gain output never exceeds the maximum-gain input. If that input is lowered below the current code, the output follows it in the same cycle, without a settle period.
- R3: Filtering is off. An evaluated sample greater than setpoint + down-margin lowers the gain by one code at the next clock edge. A sample less than setpoint − up-margin raises it by one. A sample inside that band leaves it unchanged.
- R4: The gain saturates. It stays at 0 under a persistently strong signal and at the maximum under a persistently weak one, and it never wraps.
- R5: Filtering is on. The compared value is floor((current + three previous valid samples)/4). The sample history is zero after reset. A step needs the same threshold exceeded on two consecutive evaluated samples, and the confirmation clears after a step or after an ignored sample.
- R6: After a gain step, samples are ignored for (wait+1)×8 clock cycles. The sample in the next cycle after that can step again.
- R7: If blanking is enabled when a step happens, the blanking output is high for exactly the 4 cycles that follow the step. Without a step it stays low.
- R8: Carrier sense is updated on each valid sample, using level = value + 3×(max − gain). It asserts when level ≥ setpoint and deasserts when level < setpoint − 1.
- R9: The freeze field F is non-zero. Once carrier sense has been high for at least 16×F consecutive valid samples, the gain is held until carrier sense drops.
- R10: A cycle with the sample-valid input low changes neither the gain nor carrier sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rssi_vld | input | 1 | Sample strobe |
| rssi | input | 8 | Signed measured level sample |
| max_gain | input | 5 | Gain ceiling |
| cs_level | input | 5 | Setpoint and carrier-sense threshold |
| thr_down | input | 3 | Margin above the setpoint before gain drops |
| thr_up | input | 3 | Margin below the setpoint before gain rises |
| filt_en | input | 1 | Averaging and confirmation enable |
| wait_sel | input | 3 | Settle time select, (wait+1)×8 cycles |
| freeze_sel | input | 2 | Freeze time select, 16×F samples; 0 disables |
| blank_en | input | 1 | Blanking pulse enable |
| gain_o | output | 5 | Amplifier gain code |
| blank_o | output | 1 | Blanking pulse |
| carrier_sense | output | 1 | Carrier-sense flag |

## Verification
The directed patterns are as follows:
- An in-band sample followed by a strong one separates the band test from the step.
- A sustained strong level, then a sustained weak level, shows the saturation at both ends.
- A ceiling drop shows that the clamp is combinational.
- Strobe-free cycles carrying an extreme level show that unstrobed data has no effect.

Random phases confine the levels to a few units around the setpoint, which exercises the carrier-sense hysteresis and the freeze counter. Other phases spread the levels widely with averaging on, with random settle times, or with the ceiling moved often, which separates the two-sample confirmation, the settle window length and the clamp.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // Level seen at the antenna: the measured value plus the gain headroom.
  function automatic int agc_input_level(int meas, int gmax, int gcur, int step_db);
    return meas + step_db * (gmax - gcur);
  endfunction

  function automatic logic agc_above(int v, int lvl, int margin);
    return v > (lvl + margin);
  endfunction

  function automatic logic agc_below(int v, int lvl, int margin);
    return v < (lvl - margin);
  endfunction

  function automatic int agc_hold_cycles(int wsel, int unit);
    return (wsel + 1) * unit;
  endfunction

  function automatic int agc_freeze_samples(int fsel, int unit);
    return fsel * unit;
  endfunction

endpackage

// File: rtl/agc_avg.sv
module agc_avg #(
  parameter int RSSI_W  = 8,
  parameter int AVG_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld,
  input  logic signed [RSSI_W-1:0] sample,
  output logic signed [RSSI_W-1:0] avg
);
  localparam int SH    = $clog2(AVG_LEN);
  localparam int SUM_W = RSSI_W + SH + 1;
  localparam int HN    = AVG_LEN - 1;

  logic signed [RSSI_W-1:0] hist_q [HN];
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  sum_sh;

  generate
    for (genvar i = 0; i < HN; i++) begin : g_hist
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   hist_q[i] <= '0;
          else if (vld) hist_q[i] <= sample;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   hist_q[i] <= '0;
          else if (vld) hist_q[i] <= hist_q[i-1];
        end
      end
    end
  endgenerate

  always_comb begin
    sum = SUM_W'(sample);
    for (int k = 0; k < HN; k++) sum = sum + SUM_W'(hist_q[k]);
    sum_sh = sum >>> SH;
    avg    = sum_sh[RSSI_W-1:0];
  end

endmodule

// File: rtl/agc_hold_timer.sv
module agc_hold_timer
  import agc_pkg::*;
#(
  parameter int WAIT_W    = 3,
  parameter int WAIT_UNIT = 8,
  parameter int BLANK_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [WAIT_W-1:0] wait_sel,
  input  logic              blank_en,
  output logic              hold_active,
  output logic              blank
);
  localparam int HOLD_MAX = (2 ** WAIT_W) * WAIT_UNIT;
  localparam int HW       = $clog2(HOLD_MAX + 1);
  localparam int BW       = $clog2(BLANK_LEN + 1);

  logic [HW-1:0] hold_q;
  logic [BW-1:0] blank_q;
  logic [HW-1:0] hold_len;

  assign hold_len = HW'(agc_hold_cycles(int'(wait_sel), WAIT_UNIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (step)           hold_q <= hold_len;
    else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 blank_q <= '0;
    else if (step && blank_en)  blank_q <= BW'(BLANK_LEN);
    else if (blank_q != '0)     blank_q <= blank_q - BW'(1);
  end

  assign hold_active = (hold_q != '0);
  assign blank       = (blank_q != '0);

endmodule

// File: rtl/agc_csense.sv
module agc_csense
  import agc_pkg::*;
#(
  parameter int RSSI_W   = 8,
  parameter int GAIN_W   = 5,
  parameter int LVL_W    = 5,
  parameter int FRZ_W    = 2,
  parameter int FRZ_UNIT = 16,
  parameter int STEP_DB  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld,
  input  logic signed [RSSI_W-1:0] val,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [GAIN_W-1:0]        max_gain,
  input  logic [LVL_W-1:0]         cs_level,
  input  logic [FRZ_W-1:0]         freeze_sel,
  output logic                     cs,
  output logic                     frozen
);
  localparam int RUN_MAX = ((2 ** FRZ_W) - 1) * FRZ_UNIT;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic             cs_q;
  logic [RUN_W-1:0] run_q;
  int               lvl_in;
  logic             cs_d;

  always_comb begin
    lvl_in = agc_input_level(int'(val), int'(max_gain), int'(gain), STEP_DB);
    if (cs_q) cs_d = (lvl_in >= (int'(cs_level) - 1));
    else      cs_d = (lvl_in >= int'(cs_level));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      run_q <= '0;
    end else if (vld) begin
      cs_q <= cs_d;
      if (!cs_q)                        run_q <= '0;
      else if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + RUN_W'(1);
    end
  end

  assign frozen = (freeze_sel != '0) && cs_q &&
                  (int'(run_q) >= agc_freeze_samples(int'(freeze_sel), FRZ_UNIT));
  assign cs = cs_q;

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int RSSI_W    = 8,
  parameter int GAIN_W    = 5,
  parameter int LVL_W     = 5,
  parameter int THR_W     = 3,
  parameter int WAIT_W    = 3,
  parameter int FRZ_W     = 2,
  parameter int STEP_DB   = 3,
  parameter int AVG_LEN   = 4,
  parameter int WAIT_UNIT = 8,
  parameter int BLANK_LEN = 4,
  parameter int FRZ_UNIT  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rssi_vld,
  input  logic signed [RSSI_W-1:0] rssi,
  input  logic [GAIN_W-1:0]        max_gain,
  input  logic [LVL_W-1:0]         cs_level,
  input  logic [THR_W-1:0]         thr_down,
  input  logic [THR_W-1:0]         thr_up,
  input  logic                     filt_en,
  input  logic [WAIT_W-1:0]        wait_sel,
  input  logic [FRZ_W-1:0]         freeze_sel,
  input  logic                     blank_en,
  output logic [GAIN_W-1:0]        gain_o,
  output logic                     blank_o,
  output logic                     carrier_sense
);
  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1);

  logic [GAIN_W-1:0]        gain_q, g_eff, gain_d;
  logic signed [RSSI_W-1:0] avg, val;
  logic                     over, under, over_q, under_q;
  logic                     eval_smp, want_dn, want_up;
  logic                     step_dn, step_up, step_evt;
  logic                     hold_active, frozen;

  agc_avg #(.RSSI_W(RSSI_W), .AVG_LEN(AVG_LEN)) u_avg (
    .clk(clk), .rst_n(rst_n), .vld(rssi_vld), .sample(rssi), .avg(avg)
  );

  agc_hold_timer #(.WAIT_W(WAIT_W), .WAIT_UNIT(WAIT_UNIT), .BLANK_LEN(BLANK_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .step(step_evt), .wait_sel(wait_sel),
    .blank_en(blank_en), .hold_active(hold_active), .blank(blank_o)
  );

  agc_csense #(.RSSI_W(RSSI_W), .GAIN_W(GAIN_W), .LVL_W(LVL_W), .FRZ_W(FRZ_W),
               .FRZ_UNIT(FRZ_UNIT), .STEP_DB(STEP_DB)) u_cs (
    .clk(clk), .rst_n(rst_n), .vld(rssi_vld), .val(val), .gain(g_eff),
    .max_gain(max_gain), .cs_level(cs_level), .freeze_sel(freeze_sel),
    .cs(carrier_sense), .frozen(frozen)
  );

  // Clamp to the ceiling; the register resets to all ones so the start value is the ceiling.
  assign g_eff = (gain_q > max_gain) ? max_gain : gain_q;
  assign val   = filt_en ? avg : rssi;

  always_comb begin
    over     = agc_above(int'(val), int'(cs_level), int'(thr_down));
    under    = agc_below(int'(val), int'(cs_level), int'(thr_up));
    eval_smp = rssi_vld && !hold_active && !frozen;
    want_dn  = eval_smp && over  && (!filt_en || over_q);
    want_up  = eval_smp && under && (!filt_en || under_q);
    step_dn  = want_dn && (g_eff != '0);
    step_up  = want_up && (g_eff < max_gain);
    step_evt = step_dn || step_up;
    if (step_dn)      gain_d = g_eff - ONE;
    else if (step_up) gain_d = g_eff + ONE;
    else              gain_d = g_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= '1;
    else        gain_q <= gain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (step_evt || (rssi_vld && !eval_smp)) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (rssi_vld) begin
      over_q  <= over;
      under_q <= under;
    end
  end

  assign gain_o = g_eff;

endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk #(
  parameter int GAIN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rssi_vld,
  input logic [GAIN_W-1:0] max_gain,
  input logic [GAIN_W-1:0] gain_o,
  input logic              blank_o,
  input logic              carrier_sense,
  input logic              step_evt,
  input logic              hold_active,
  input logic              frozen
);
  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1);

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(max_gain) && (gain_o != $past(gain_o))) |->
      ((gain_o == $past(gain_o) + ONE) || (gain_o == $past(gain_o) - ONE))); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gain_o) == '0) |-> (gain_o <= ONE)); // R4

  AST_HOLD_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> ((gain_o == $past(gain_o)) || (max_gain != $past(max_gain)))); // R6

  AST_BLANK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_o) |-> $past(step_evt)); // R7

  AST_CS_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_sense != $past(carrier_sense)) |-> $past(rssi_vld)); // R8

  AST_FREEZE_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ((gain_o == $past(gain_o)) || (max_gain != $past(max_gain)))); // R9

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rssi_vld |-> !step_evt); // R10

endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rssi_vld(rssi_vld), .max_gain(max_gain),
  .gain_o(gain_o), .blank_o(blank_o), .carrier_sense(carrier_sense),
  .step_evt(step_evt), .hold_active(hold_active), .frozen(frozen)
);

// File: tb/agc_gain_ctrl_tb.sv
module agc_gain_ctrl_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rssi_vld = 1'b0;
  logic signed [7:0] rssi = '0;
  logic [4:0]        max_gain = 5'd20;
  logic [4:0]        cs_level = 5'd10;
  logic [2:0]        thr_down = 3'd2;
  logic [2:0]        thr_up = 3'd3;
  logic              filt_en = 1'b0;
  logic [2:0]        wait_sel = 3'd0;
  logic [1:0]        freeze_sel = 2'd0;
  logic              blank_en = 1'b1;
  logic [4:0]        gain_o;
  logic              blank_o;
  logic              carrier_sense;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Bench-side state of the expected behaviour
  int m_gq, m_hold, m_blank, m_run;
  int m_h [3];
  bit m_ov, m_un, m_cs;

  always #5 clk = ~clk;

  agc_gain_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rssi_vld(rssi_vld), .rssi(rssi),
    .max_gain(max_gain), .cs_level(cs_level), .thr_down(thr_down), .thr_up(thr_up),
    .filt_en(filt_en), .wait_sel(wait_sel), .freeze_sel(freeze_sel), .blank_en(blank_en),
    .gain_o(gain_o), .blank_o(blank_o), .carrier_sense(carrier_sense)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_gq = 31; m_hold = 0; m_blank = 0; m_run = 0;
    m_ov = 0; m_un = 0; m_cs = 0;
    for (int i = 0; i < 3; i++) m_h[i] = 0;
  endtask

  function automatic int clamp_g(int g, int mx);
    return (g > mx) ? mx : g;
  endfunction

  task automatic model_step();
    int mx, g0, gn, v, lvl, lin, nrun;
    bit fz, ev, ov, un, st;
    mx  = int'(max_gain);
    lvl = int'(cs_level);
    g0  = clamp_g(m_gq, mx);
    if (filt_en) v = (int'(rssi) + m_h[0] + m_h[1] + m_h[2]) >>> 2;
    else         v = int'(rssi);
    fz = (freeze_sel != 0) && m_cs && (m_run >= 16 * int'(freeze_sel));
    ev = rssi_vld && (m_hold == 0) && !fz;
    ov = v > lvl + int'(thr_down);
    un = v < lvl - int'(thr_up);
    gn = g0; st = 0;
    if (ev && ov && (!filt_en || m_ov) && g0 > 0) begin gn = g0 - 1; st = 1; end
    else if (ev && un && (!filt_en || m_un) && g0 < mx) begin gn = g0 + 1; st = 1; end
    if (st || (rssi_vld && !ev)) begin m_ov = 0; m_un = 0; end
    else if (rssi_vld) begin m_ov = ov; m_un = un; end
    if (st) m_hold = (int'(wait_sel) + 1) * 8;
    else if (m_hold > 0) m_hold--;
    if (st && blank_en) m_blank = 4;
    else if (m_blank > 0) m_blank--;
    if (rssi_vld) begin
      lin  = v + 3 * (mx - g0);
      nrun = m_cs ? ((m_run < 48) ? m_run + 1 : 48) : 0;
      m_cs = m_cs ? (lin >= lvl - 1) : (lin >= lvl);
      m_run = nrun;
      m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = int'(rssi);
    end
    m_gq = gn;
  endtask

  task automatic cmp(string tag);
    chk({tag, " gain"}, int'(gain_o), clamp_g(m_gq, int'(max_gain)));
    chk({tag, " blank"}, int'(blank_o), int'(m_blank != 0));
    chk({tag, " carrier"}, int'(carrier_sense), int'(m_cs));
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic rand_level(int spread);
    int t;
    t = int'(cs_level) + int'($urandom_range(2 * spread, 0)) - spread;
    if ($urandom_range(15, 0) == 0) t = ($urandom_range(1, 0) == 1) ? 127 : -128;
    if (t > 127) t = 127;
    if (t < -128) t = -128;
    rssi = 8'(t);
  endtask

  task automatic run_phase(string tag);
    for (int b = 0; b < 12; b++) begin
      max_gain = 5'(8 + $urandom_range(23, 0));
      cs_level = 5'($urandom_range(31, 0));
      thr_down = 3'($urandom_range(7, 0));
      thr_up   = 3'($urandom_range(7, 0));
      filt_en = 0; blank_en = 1; freeze_sel = 0;
      wait_sel = 3'($urandom_range(1, 0));
      if (tag == "R5") filt_en = 1;
      if (tag == "R6") wait_sel = 3'($urandom_range(7, 0));
      if (tag == "R7") blank_en = 1'($urandom_range(1, 0));
      if (tag == "R9") freeze_sel = 2'($urandom_range(3, 1));
      for (int c = 0; c < 150; c++) begin
        rssi_vld = (tag == "R10") ? ($urandom_range(9, 0) < 3) : ($urandom_range(9, 0) != 0);
        rand_level((tag == "R8" || tag == "R9") ? 5 : 20);
        if (tag == "R2" && (c % 20) == 19) max_gain = 5'($urandom_range(31, 0));
        cyc(tag);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 gain", int'(gain_o), 20);
    chk("R1 blank", int'(blank_o), 0);
    chk("R1 carrier", int'(carrier_sense), 0);
    rst_n = 1'b1;
    cyc("R1");
    chk("R1 gain after release", int'(gain_o), 20);

    // In band, then one strong sample
    rssi_vld = 1; rssi = 8'sd11;
    cyc("R3");
    chk("R3 in band", int'(gain_o), 20);
    rssi = 8'sd13;
    cyc("R3");
    chk("R3 step down", int'(gain_o), 19);
    chk("R7 blank on", int'(blank_o), 1);
    repeat (4) cyc("R7");
    chk("R7 blank off", int'(blank_o), 0);
    repeat (4) cyc("R6");
    chk("R6 held", int'(gain_o), 19);
    cyc("R6");
    chk("R6 next step", int'(gain_o), 18);

    // Saturation at both ends
    blank_en = 0; rssi = 8'sd100;
    repeat (300) cyc("R4");
    chk("R4 floor", int'(gain_o), 0);
    max_gain = 5'd3; rssi = -8'sd100;
    repeat (60) cyc("R4");
    chk("R4 ceiling", int'(gain_o), 3);
    max_gain = 5'd1;
    #1;
    chk("R2 clamp", int'(gain_o), 1);
    cyc("R2");

    // Unstrobed data
    rssi_vld = 0; rssi = 8'sd100;
    repeat (40) cyc("R10");
    chk("R10 gain", int'(gain_o), 1);
    chk("R10 carrier", int'(carrier_sense), 0);

    run_phase("R3");
    run_phase("R5");
    run_phase("R6");
    run_phase("R7");
    run_phase("R8");
    run_phase("R9");
    run_phase("R10");
    run_phase("R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule